// File: doc/BRIEF.md
# Oscillator Calibration Cycle Counter

This block measures how fast one clock runs compared with another. The block and all of its logic run on the divided system clock. Software first picks a pacing oscillator from five inputs. As an alternative, it can pace the measurement from an external input. It then loads a window length in pacing periods and writes the start bit. The block waits for the first pacing rising edge after the start. From that edge on, it counts events until the window has run its length. The events are either cycles of the divided system clock or rising edges of a second chosen oscillator. The total is kept in a read-only result register.

Every oscillator input and the external input pass through a two-flop synchronizer, followed by a rising-edge detector in the system clock domain. While a measurement is in flight, the start bit reads as 1. The hardware clears it when the new result is in place. Configuration writes made during a measurement are dropped, so the settings cannot change partway through a window.

Top module: `osc_cal_counter`

## Requirements
- R1: After reset, the control register (address 0x10), the window register (0x14) and the result register (0x18) all read 0.
- R2: The control register holds the pacing select in bits [2:0], the start/busy bit in bit 3, the pacing-source bit in bit 4 and the event select in bits [7:5]. The window register holds a 16-bit length in bits [15:0]. Both read back what was written while idle. Writes to the result register have no effect.
- R3: Writing control with bit 3 set while idle starts a measurement. Bit 3 reads 1 from the next cycle until the result is updated, then reads 0.
- R4: With event select 0 (system clock cycles), the result equals the window length times the pacing period in system clock cycles. The count starts at the first pacing rising edge after the start write, not at the write itself.
- R5: A window length of 0 or of 1 gives a window of exactly one pacing period.
- R6: With pacing-source bit 0, pacing select values 0..4 pick oscillator inputs osc_in[0]..osc_in[4]. The inputs not selected have no effect on the result.
- R7: With pacing-source bit 1, rising edges of ext_gate_in pace the window, and the selected oscillator is ignored.
- R8: Event select values 1, 2, 3 and 4 count synchronized rising edges of osc_in[0], osc_in[1], osc_in[2] and osc_in[4] respectively, within the window.
- R9: Event select values 5, 6 and 7 select no source, and the measurement completes with a result of 0.
- R10: While a measurement is busy, writes to the control and window registers are ignored. A repeated start write has no effect on the running window.
- R11: The result register keeps the last completed count throughout a following measurement, until that measurement completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided system clock; all logic runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| osc_in | input | 5 | Asynchronous oscillator inputs, index order as in R6 |
| ext_gate_in | input | 1 | Asynchronous external pacing input |

## Verification
The hardest case to reach from the ports is an exact count while a start write lands in an arbitrary phase of the pacing clock. The bench derives every oscillator from one tick counter in the system clock. All rising edges then fall on multiples of each period, and each synchronizer path adds the same delay. As a result, the expected totals are exact products or quotients. The busy-time write case is reached by issuing conflicting control, window and start writes immediately after a start. The register readback and the final result then show that those writes were dropped.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;

   localparam int unsigned OSC_COUNT = 5;

   typedef enum logic [1:0] {
      CAL_IDLE = 2'd0,
      CAL_ARM  = 2'd1,
      CAL_RUN  = 2'd2
   } cal_state_e;

   // pacing source: select 0..4 map to oscillator 0..4, others pick nothing
   function automatic logic pick_pace(input logic [2:0] sel, input logic [OSC_COUNT-1:0] rise);
      logic r;
      case (sel)
         3'd0:    r = rise[0];
         3'd1:    r = rise[1];
         3'd2:    r = rise[2];
         3'd3:    r = rise[3];
         3'd4:    r = rise[4];
         default: r = 1'b0;
      endcase
      return r;
   endfunction

   // counted event: 0 = every system cycle, 1..4 = oscillator 0,1,2,4
   function automatic logic pick_event(input logic [2:0] sel, input logic [OSC_COUNT-1:0] rise);
      logic r;
      case (sel)
         3'd0:    r = 1'b1;
         3'd1:    r = rise[0];
         3'd2:    r = rise[1];
         3'd3:    r = rise[2];
         3'd4:    r = rise[4];
         default: r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("osc_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= '0;
         last_q <= 1'b0;
      end else begin
         chain  <= {chain[STAGES-2:0], async_in};
         last_q <= chain[STAGES-1];
      end
   end

   assign rise = chain[STAGES-1] & ~last_q;

   // R6
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/osc_cal_engine.sv
module osc_cal_engine
   import osc_cal_pkg::*;
#(
   parameter int unsigned WIN_W = 16,
   parameter int unsigned RES_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             pace,
   input  logic             evt,
   input  logic [WIN_W-1:0] win,
   output logic             busy,
   output logic [RES_W-1:0] result
);

   if (WIN_W < 2 || RES_W < 2) begin : g_bad_width
      $error("osc_cal_engine: widths too small");
   end

   cal_state_e       state;
   logic [WIN_W-1:0] dcnt;
   logic [RES_W-1:0] acc;
   logic             finish;

   assign finish = (state == CAL_RUN) && pace && (dcnt == WIN_W'(1));
   assign busy   = (state != CAL_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= CAL_IDLE;
         dcnt   <= '0;
         acc    <= '0;
         result <= '0;
      end else begin
         case (state)
            CAL_IDLE: begin
               if (start) begin
                  acc   <= '0;
                  state <= CAL_ARM;
               end
            end
            CAL_ARM: begin
               if (pace) begin
                  dcnt  <= (win > WIN_W'(1)) ? win : WIN_W'(1);
                  state <= CAL_RUN;
               end
            end
            CAL_RUN: begin
               acc <= acc + RES_W'(evt);
               if (pace) begin
                  if (dcnt == WIN_W'(1)) begin
                     result <= acc + RES_W'(evt);
                     state  <= CAL_IDLE;
                  end else begin
                     dcnt <= dcnt - WIN_W'(1);
                  end
               end
            end
            default: state <= CAL_IDLE;
         endcase
      end
   end

   // R11
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !finish |=> $stable(result));

   // R5
   dcnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CAL_RUN) |-> (dcnt != '0));

   // R4
   arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CAL_ARM) |-> (acc == '0));

   // R3
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> !busy);

endmodule

// File: rtl/osc_cal_counter.sv
module osc_cal_counter
   import osc_cal_pkg::*;
#(
   parameter int unsigned     ADDR_W      = 8,
   parameter int unsigned     DATA_W      = 32,
   parameter int unsigned     WIN_W       = 16,
   parameter int unsigned     RES_W       = 32,
   parameter int unsigned     SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h10,
   parameter logic [ADDR_W-1:0] WIN_ADDR  = 'h14,
   parameter logic [ADDR_W-1:0] RES_ADDR  = 'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [OSC_COUNT-1:0] osc_in,
   input  logic              ext_gate_in
);

   localparam int unsigned SRC_COUNT = OSC_COUNT + 1;
   localparam int unsigned CTRL_W    = 8;

   if (DATA_W < CTRL_W || WIN_W > DATA_W || RES_W > DATA_W) begin : g_bad_bus
      $error("osc_cal_counter: bus width too small for registers");
   end

   logic [2:0]       pace_sel;
   logic             ext_sel;
   logic [2:0]       evt_sel;
   logic [WIN_W-1:0] win_q;
   logic             busy;
   logic [RES_W-1:0] result;
   logic             wr_ctrl;
   logic             wr_win;
   logic             start_req;

   assign wr_ctrl   = bus_wr && (bus_addr == CTRL_ADDR) && !busy;
   assign wr_win    = bus_wr && (bus_addr == WIN_ADDR)  && !busy;
   assign start_req = wr_ctrl && bus_wdata[3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pace_sel <= '0;
         ext_sel  <= 1'b0;
         evt_sel  <= '0;
         win_q    <= '0;
      end else begin
         if (wr_ctrl) begin
            pace_sel <= bus_wdata[2:0];
            ext_sel  <= bus_wdata[4];
            evt_sel  <= bus_wdata[7:5];
         end
         if (wr_win) begin
            win_q <= bus_wdata[WIN_W-1:0];
         end
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata[DATA_W-1:WIN_W];

   // synchronizers for every oscillator plus the external input
   logic [SRC_COUNT-1:0] src_raw;
   logic [SRC_COUNT-1:0] src_rise;
   assign src_raw = {ext_gate_in, osc_in};

   for (genvar g = 0; g < SRC_COUNT; g++) begin : g_sync
      osc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk      (clk),
         .rst_n    (rst_n),
         .async_in (src_raw[g]),
         .rise     (src_rise[g])
      );
   end

   logic pace;
   logic evt;
   assign pace = ext_sel ? src_rise[OSC_COUNT] : pick_pace(pace_sel, src_rise[OSC_COUNT-1:0]);
   assign evt  = pick_event(evt_sel, src_rise[OSC_COUNT-1:0]);

   osc_cal_engine #(.WIN_W(WIN_W), .RES_W(RES_W)) u_engine (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start_req),
      .pace   (pace),
      .evt    (evt),
      .win    (win_q),
      .busy   (busy),
      .result (result)
   );

   always_comb begin
      if (bus_addr == CTRL_ADDR)
         bus_rdata = DATA_W'({evt_sel, ext_sel, busy, pace_sel});
      else if (bus_addr == WIN_ADDR)
         bus_rdata = DATA_W'(win_q);
      else if (bus_addr == RES_ADDR)
         bus_rdata = DATA_W'(result);
      else
         bus_rdata = '0;
   end

   // R10
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(pace_sel) && $stable(ext_sel) && $stable(evt_sel) && $stable(win_q)));

   // R3
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == CTRL_ADDR) && bus_wdata[3] && !busy) |=> busy);

endmodule

// File: tb/sim_osc_cal_counter.sv
module sim_osc_cal_counter;

   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_CTRL = 8'h10;
   localparam logic [7:0] A_WIN  = 8'h14;
   localparam logic [7:0] A_RES  = 8'h18;
   localparam int P0 = 40, P1 = 4, P2 = 24, P3 = 30, P4 = 8, PE = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [4:0]  osc_in = '0;
   logic        ext_gate_in = 1'b0;

   int checks = 0;
   int fails  = 0;
   int tick   = 0;
   int cycles = 0;
   bit finished = 1'b0;

   int          exp_q[$];
   string       tag_q[$];
   logic [31:0] res_sample;
   event        res_ev;

   osc_cal_counter u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_wr      (bus_wr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .osc_in      (osc_in),
      .ext_gate_in (ext_gate_in)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // all oscillators derived from one tick so that rising edges align
   always @(negedge clk) begin
      osc_in[0]   = (tick % P0) < (P0 / 2);
      osc_in[1]   = (tick % P1) < (P1 / 2);
      osc_in[2]   = (tick % P2) < (P2 / 2);
      osc_in[3]   = (tick % P3) < (P3 / 2);
      osc_in[4]   = (tick % P4) < (P4 / 2);
      ext_gate_in = (tick % PE) < (PE / 2);
      tick++;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic logic [31:0] ctrl_word(input int ps, input int ext, input int es, input int st);
      return 32'((es << 5) | (ext << 4) | (st << 3) | ps);
   endfunction

   task automatic start_cal(input string tag, input int ps, input int ext, input int es,
                            input int win, input int exp);
      bus_write(A_WIN, 32'(win));
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      bus_write(A_CTRL, ctrl_word(ps, ext, es, 1));
   endtask

   task automatic finish_cal();
      logic [31:0] d;
      int n = 0;
      d = 32'h8;
      while (d[3] && n < 4000) begin
         bus_read(A_CTRL, d);
         n++;
      end
      bus_read(A_RES, res_sample);
      -> res_ev;
      @(negedge clk);
   endtask

   task automatic run_cal(input string tag, input int ps, input int ext, input int es,
                          input int win, input int exp);
      start_cal(tag, ps, ext, es, win, exp);
      finish_cal();
   endtask

   // monitor: pops the expected count and compares with the observed result
   always begin
      @(res_ev);
      if (exp_q.size() == 0) begin
         check("scoreboard underflow", 32'd1, 32'd0);
      end else begin
         check(tag_q.pop_front(), res_sample, 32'(exp_q.pop_front()));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000 && !finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      bus_read(A_CTRL, d); check("R1 ctrl reset", d, 32'h0);
      bus_read(A_WIN, d);  check("R1 window reset", d, 32'h0);
      bus_read(A_RES, d);  check("R1 result reset", d, 32'h0);

      // R2 readback of fields, result not writable
      bus_write(A_WIN, 32'h0000_1234);
      bus_read(A_WIN, d);  check("R2 window readback", d, 32'h1234);
      bus_write(A_CTRL, ctrl_word(3, 1, 6, 0));
      bus_read(A_CTRL, d); check("R2 ctrl readback", d, 32'hD3);
      bus_write(A_RES, 32'hFFFF_FFFF);
      bus_read(A_RES, d);  check("R2 result write ignored", d, 32'h0);

      // R3 busy bit after start
      start_cal("R4 sysclk window 3 pace0", 0, 0, 0, 3, 3 * P0);
      bus_read(A_CTRL, d); check("R3 start bit busy", 32'(d[3]), 32'd1);
      finish_cal();
      bus_read(A_CTRL, d); check("R3 start bit cleared", 32'(d[3]), 32'd0);

      // R6 pacing select over each oscillator
      run_cal("R6 pace1 window 10", 1, 0, 0, 10, 10 * P1);
      run_cal("R6 pace2 window 2", 2, 0, 0, 2, 2 * P2);
      run_cal("R6 pace3 window 3", 3, 0, 0, 3, 3 * P3);
      run_cal("R6 pace4 window 5", 4, 0, 0, 5, 5 * P4);

      // R7 external pacing
      run_cal("R7 external window 3", 0, 1, 0, 3, 3 * PE);

      // R8 event select on oscillators
      run_cal("R8 events osc0", 0, 0, 1, 3, 3);
      run_cal("R8 events osc1", 0, 0, 2, 3, 3 * P0 / P1);
      run_cal("R8 events osc2", 0, 0, 3, 3, 3 * P0 / P2);
      run_cal("R8 events osc4", 0, 0, 4, 3, 3 * P0 / P4);

      // R9 reserved event selects
      run_cal("R9 event sel 5", 0, 0, 5, 1, 0);
      run_cal("R9 event sel 6", 0, 0, 6, 1, 0);
      run_cal("R9 event sel 7", 0, 0, 7, 1, 0);

      // R5 short windows
      run_cal("R5 window 0", 0, 0, 0, 0, P0);
      run_cal("R5 window 1", 0, 0, 0, 1, P0);

      // R10 and R11 writes during busy; previous result held
      start_cal("R10 busy writes ignored", 0, 0, 0, 4, 4 * P0);
      bus_read(A_RES, d);  check("R11 result held during run", d, 32'(P0));
      bus_write(A_WIN, 32'd9);
      bus_write(A_CTRL, ctrl_word(1, 1, 2, 1));
      bus_read(A_WIN, d);  check("R10 window unchanged", d, 32'd4);
      bus_read(A_CTRL, d); check("R10 ctrl unchanged", d & 32'hF7, 32'h0);
      bus_read(A_RES, d);  check("R11 result held later", d, 32'(P0));
      finish_cal();

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) check("scoreboard leftover", 32'(exp_q.size()), 32'd0);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule